// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a parameterised set of interrupt lines (up to 32) into one request line for a processor. Each line has a fixed kind chosen when the block is built. An edge line latches a request when it goes from low to high. A level line asserts its request on every cycle that it is high. A latched request stays in a status bit until software clears it.

Software reaches the block through a simple synchronous word register port. It can read the raw status and the enabled (pending) requests, and it can clear requests by writing ones to an acknowledge word. The enable mask can be written whole, or bits can be set or cleared through two separate words so that no read-modify-write is needed. A vector word returns the number of the lowest-numbered pending line, or all-ones when nothing is pending. The processor request line is the OR of the pending bits, passed on only when both bits of a two-bit master control word are set.

The register port has no back-pressure. A request with `bus_req` high is accepted on the clock edge where it is seen. Read data appears on `bus_rdata` after that edge and stays there until the next read. Only byte address bits [4:2] select a word, so the low two bits are ignored.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the status, enable and master words are zero, `irq_out` is low, and the vector word reads 0xFFFFFFFF.
- R2: For a line whose bit in `KIND_MASK` is 1 (edge kind), the status bit is set on the clock edge where the line is first sampled high after being sampled low. A line that stays high does not set the bit again once it has been cleared.
- R3: For a line whose bit in `KIND_MASK` is 0 (level kind), the status bit is set on every edge where the line is sampled high. An acknowledge while the line is still high is therefore undone on that same edge.
- R4: Writing word 0x0C clears each status bit whose data bit is 1 and leaves the other status bits alone. When a set and a clear hit the same bit on the same edge, the set wins. Status bits never drop without such a write.
- R5: Writing word 0x10 sets, and writing word 0x14 clears, the enable bits whose data bit is 1. All other enable bits keep their value.
- R6: Writing word 0x08 replaces the whole enable mask, so writing 0 disables every line.
- R7: Word 0x04 reads status AND enable. Word 0x00 reads status, and word 0x08 reads enable.
- R8: Word 0x18 reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R9: Word 0x1C holds two bits, [0] master enable and [1] output enable, and reads back the value written. `irq_out` is high exactly when some pending bit is set and both of these bits are 1.
- R10: Words 0x0C, 0x10 and 0x14 read 0. Bits at or above `NUM_IN` read 0 in every word and cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Interrupt lines, one per source |
| bus_req | input | 1 | Register access strobe, taken on the clock edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Request to the processor |

## Verification
A line value sampled on one edge shows up in status, pending and `irq_out` just after that same edge. So the change is due one edge after the stimulus, and the request output adds no extra register. A write takes effect on the edge that accepts it. A read returns the values held just before its accepting edge and appears after that edge. The bench drives inputs on falling edges, advances a behavioural model on each rising edge, and compares `irq_out` and any due read data on the following falling edge, so each comparison lands on the first cycle where the result is due.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int BUS_AW = 5;
  localparam int BUS_DW = 32;

  typedef enum logic [2:0] {
    SLOT_STATUS = 3'd0,
    SLOT_PEND   = 3'd1,
    SLOT_EN     = 3'd2,
    SLOT_ACK    = 3'd3,
    SLOT_SETEN  = 3'd4,
    SLOT_CLREN  = 3'd5,
    SLOT_VEC    = 3'd6,
    SLOT_MASTER = 3'd7
  } reg_slot_e;

  localparam logic [BUS_DW-1:0] NO_VECTOR = '1;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int          NUM_IN    = 32,
  parameter logic [31:0] KIND_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] clr_bits,
  output logic [NUM_IN-1:0] status
);
  logic [NUM_IN-1:0] set_bits;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_line
    if (KIND_MASK[i]) begin : g_edge
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= irq_in[i];
      end
      assign set_bits[i] = irq_in[i] & ~last_q;
    end else begin : g_level
      assign set_bits[i] = irq_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           status[i] <= 1'b0;
      else if (set_bits[i]) status[i] <= 1'b1;
      else if (clr_bits[i]) status[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_IN = 32,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0] pend,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_vec_pkg::*;
#(
  parameter int NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  reg_slot_e         slot,
  input  logic [NUM_IN-1:0] wbits,
  input  logic [1:0]        wmst,
  output logic [NUM_IN-1:0] enable,
  output logic [1:0]        master
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      master <= 2'b00;
    end else if (wr_stb) begin
      unique case (slot)
        SLOT_EN:     enable <= wbits;
        SLOT_SETEN:  enable <= enable | wbits;
        SLOT_CLREN:  enable <= enable & ~wbits;
        SLOT_MASTER: master <= wmst;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          NUM_IN    = 32,
  parameter logic [31:0] KIND_MASK = 32'h0000_0000,
  localparam int         IDX_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_out
);
  reg_slot_e         slot;
  logic              wr_stb;
  logic [NUM_IN-1:0] ack_bits;
  logic [NUM_IN-1:0] cap_status;
  logic [NUM_IN-1:0] en_q;
  logic [1:0]        mst_q;
  logic [NUM_IN-1:0] pend;
  logic              any_pend;
  logic [IDX_W-1:0]  win_idx;
  logic [BUS_DW-1:0] stat_w, pend_w, en_w, rd_mux;

  assign slot     = reg_slot_e'(bus_addr[4:2]);
  assign wr_stb   = bus_req & bus_we;
  assign ack_bits = (wr_stb && slot == SLOT_ACK) ? bus_wdata[NUM_IN-1:0] : '0;

  irq_capture #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .clr_bits(ack_bits), .status(cap_status)
  );

  irq_regfile #(.NUM_IN(NUM_IN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .slot(slot),
    .wbits(bus_wdata[NUM_IN-1:0]), .wmst(bus_wdata[1:0]),
    .enable(en_q), .master(mst_q)
  );

  assign pend = cap_status & en_q;

  irq_prio_enc #(.NUM_IN(NUM_IN)) u_enc (
    .pend(pend), .found(any_pend), .idx(win_idx)
  );

  assign irq_out = any_pend & mst_q[0] & mst_q[1];

  always_comb begin
    stat_w = '0; stat_w[NUM_IN-1:0] = cap_status;
    pend_w = '0; pend_w[NUM_IN-1:0] = pend;
    en_w   = '0; en_w[NUM_IN-1:0]   = en_q;
    unique case (slot)
      SLOT_STATUS: rd_mux = stat_w;
      SLOT_PEND:   rd_mux = pend_w;
      SLOT_EN:     rd_mux = en_w;
      SLOT_VEC:    rd_mux = any_pend ? {{(BUS_DW-IDX_W){1'b0}}, win_idx} : NO_VECTOR;
      SLOT_MASTER: rd_mux = {{(BUS_DW-2){1'b0}}, mst_q};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (bus_req && !bus_we) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int NUM_IN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] irq_in,
  input logic              bus_req,
  input logic              bus_we,
  input logic [4:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq_out,
  input logic [NUM_IN-1:0] status,
  input logic [NUM_IN-1:0] enable,
  input logic [1:0]        master
);
  logic wr_ack, wr_set, wr_clr, wr_mst;
  assign wr_ack = bus_req && bus_we && bus_addr[4:2] == 3'd3;
  assign wr_set = bus_req && bus_we && bus_addr[4:2] == 3'd4;
  assign wr_clr = bus_req && bus_we && bus_addr[4:2] == 3'd5;
  assign wr_mst = bus_req && bus_we && bus_addr[4:2] == 3'd7;

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> master == 2'b11); // R9
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (status & enable) != '0); // R7
  AST_ACK_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && (&bus_wdata[NUM_IN-1:0]) && irq_in == '0) |=> status == '0); // R4
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack |=> (status & $past(status)) == $past(status)); // R4
  AST_SETEN_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> enable == ($past(enable) | $past(bus_wdata[NUM_IN-1:0]))); // R5
  AST_CLREN_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> enable == ($past(enable) & ~$past(bus_wdata[NUM_IN-1:0]))); // R5
  AST_MASTER_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mst |=> master == $past(bus_wdata[1:0])); // R9
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_out(irq_out), .status(cap_status), .enable(en_q), .master(mst_q)
);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
  localparam int          N    = 20;
  localparam logic [31:0] KIND = 32'h000F_00FF; // edge: 0..7,16..19 level: 8..15
  localparam logic [31:0] VMASK = (32'h1 << N) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  irq_vec_ctrl #(.NUM_IN(N), .KIND_MASK(KIND)) u_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk; // 50 MHz

  int    total = 0, bad = 0;
  string phase = "R1";

  // behavioural reference model
  logic [31:0] m_stat = 0, m_en = 0, m_prev = 0;
  logic [1:0]  m_mst = 0;
  logic [31:0] exp_rd = 0;
  int          rd_issued = 0, rd_checked = 0;

  function automatic logic [31:0] m_read(input int slot);
    logic [31:0] p;
    p = m_stat & m_en;
    case (slot)
      0: return m_stat;
      1: return p;
      2: return m_en;
      6: begin
        for (int i = 0; i < 32; i++) if (p[i]) return i;
        return 32'hFFFF_FFFF;
      end
      7: return {30'd0, m_mst};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_prev = 0; m_mst = 0;
    end else begin
      logic [31:0] setv, ackv, inw;
      int slot;
      slot = bus_addr[4:2];
      inw = 32'(irq_in);
      if (bus_req && !bus_we) begin exp_rd = m_read(slot); rd_issued++; end
      setv = 0;
      for (int i = 0; i < N; i++)
        setv[i] = KIND[i] ? (inw[i] & ~m_prev[i]) : inw[i];
      ackv = (bus_req && bus_we && slot == 3) ? (bus_wdata & VMASK) : 0;
      m_stat = (m_stat & ~ackv) | setv;
      m_prev = inw;
      if (bus_req && bus_we) begin
        if (slot == 2) m_en = bus_wdata & VMASK;
        if (slot == 4) m_en = m_en | (bus_wdata & VMASK);
        if (slot == 5) m_en = m_en & ~bus_wdata;
        if (slot == 7) m_mst = bus_wdata[1:0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_irq;
      exp_irq = ((m_stat & m_en) != 0) && m_mst == 2'b11;
      total++;
      if (irq_out !== exp_irq) begin
        bad++;
        $display("FAIL [%s R9] irq_out actual=%0b expected=%0b", phase, irq_out, exp_irq);
      end
      if (rd_issued != rd_checked) begin
        rd_checked = rd_issued;
        total++;
        if (bus_rdata !== exp_rd) begin
          bad++;
          $display("FAIL [%s] rdata actual=%h expected=%h", phase, bus_rdata, exp_rd);
        end
      end
    end
  end

  task automatic wr(input int slot, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 5'(slot * 4); bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input int slot);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 5'(slot * 4 + 1); // low bits ignored
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL [watchdog] actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    hold(3);
    total++;
    if (irq_out !== 1'b0) begin bad++; $display("FAIL [R1] irq_out actual=%0b expected=0", irq_out); end
    rst_n = 1;
    rd(0); rd(2); rd(6); rd(7);

    phase = "R9 R5";
    wr(7, 32'h3); rd(7);
    wr(4, 32'hFFFF_FFFF); rd(2);          // R10: high bits stay 0

    phase = "R2";
    @(negedge clk) irq_in[3] = 1; @(negedge clk) irq_in[3] = 0;
    rd(0); rd(6);
    @(negedge clk) irq_in[5] = 1;
    hold(2); wr(3, 32'h28); hold(3); rd(0); // no re-set while held high
    irq_in[5] = 0;

    phase = "R3 R4";
    @(negedge clk) irq_in[9] = 1;
    hold(2); wr(3, 32'h200); rd(0);       // level re-asserts
    @(negedge clk) irq_in[9] = 0;
    wr(3, 32'h200); rd(0);

    phase = "R4 set wins";
    @(negedge clk);
    irq_in[2] = 1; bus_req = 1; bus_we = 1; bus_addr = 5'h0C; bus_wdata = 32'h4;
    @(negedge clk); bus_req = 0; bus_we = 0;
    rd(0); irq_in[2] = 0;

    phase = "R8 R7";
    @(negedge clk) irq_in[12] = 1; irq_in[17] = 1;
    @(negedge clk) irq_in[17] = 0;
    rd(6); wr(5, 32'h4); rd(6); rd(1);
    wr(5, 32'h1000); rd(6); rd(1);
    wr(4, 32'h4); rd(6);

    phase = "R6";
    wr(2, 32'h0); rd(6); rd(2);
    wr(2, 32'h0002_0000); rd(1);

    phase = "R9";
    wr(7, 32'h1); rd(7); wr(7, 32'h2); rd(7); wr(7, 32'h3);

    phase = "R10";
    rd(3); rd(4); rd(5);
    wr(3, 32'hFFFF_FFFF); irq_in = '0; wr(3, 32'hFFFF_FFFF); rd(0);

    phase = "R2 R3 R4 R5 R6 R7 R8 random";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      irq_in    = N'($urandom);
      bus_req   = ($urandom % 3) != 0;
      bus_we    = $urandom % 2;
      bus_addr  = 5'($urandom);
      bus_wdata = $urandom;
    end
    @(negedge clk) bus_req = 0;
    hold(4);
    finish_run();
  end
endmodule